// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Tail-Chaining

This block sits next to a single-issue core and decides which interrupt handler runs. Each request line is a level: a source is pending for as long as its request level and its enable are both high. No request is latched or counted, so a line that is raised again while it is still high adds nothing. Each line carries a group priority and a sub-priority. A smaller value means more urgent. The group priority alone decides preemption. The sub-priority only orders requests that are waiting, and ties in both fields go to the lowest vector number.

The arbiter tracks the running handler and keeps a fixed-depth nesting stack of the handlers it has preempted. It reports each decision as a one-cycle strobe together with the vector number. A strobe is registered one cycle after the inputs that caused it. There are four decisions: enter from idle, preempt, tail-chain and return. When the core signals that a handler is done and another request qualifies, the arbiter issues a tail-chain instead of a return. The core then skips the unstack and restack and jumps straight to the new vector. That vector may be the completing handler's own vector if its source is still pending.

Top module: `irq_prio_arb`

## Requirements
- R1: `pendMask` bit i equals `reqLevel[i] & reqEn[i]` in the same cycle, and a source whose enable is low is never entered.
- R2: With no handler active and at least one pending source, `enterStb` pulses one cycle later with `vecNum` set to the selected vector. `activeValid` rises and `activeVec` equals that vector.
- R3: Selection among pending sources picks the lowest group priority, then the lowest sub-priority, then the lowest vector number. Group priority of vector i is `grpPrio[i*GRP_W +: GRP_W]` and sub-priority is `subPrio[i*SUB_W +: SUB_W]`.
- R4: A pending source whose group priority equals the running handler's never preempts it, whatever its sub-priority.
- R5: A pending source whose group priority is strictly lower than the running handler's causes `preemptStb` one cycle later. The running handler is pushed onto the nesting stack.
- R6: On `handlerDone`, if the best pending source has a strictly lower group priority than the top stacked handler, or the stack is empty and any source is pending, `chainStb` pulses instead of `returnStb`. The best source is the one ranked first by R3, and it may be the completing handler's own vector.
- R7: On `handlerDone` with a non-empty stack and no pending source that beats the top stacked handler's group priority, `returnStb` pulses and the top stacked handler becomes active again, shown on `vecNum` and `activeVec`.
- R8: On `handlerDone` with an empty stack and nothing pending, `returnStb` pulses with `vecNum` 0 and `activeValid` falls.
- R9: With the nesting stack holding DEPTH entries, no preemption takes place until a completion frees a level.
- R10: At most one of the four strobes is high in any cycle. Each strobe lasts one cycle, and `vecNum` is 0 in cycles with no strobe.
- R11: `handlerDone` while idle with nothing pending produces no strobe and leaves `activeValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqLevel | input | NUM_SRC | Request levels, one per vector |
| reqEn | input | NUM_SRC | Per-vector enables |
| grpPrio | input | NUM_SRC*GRP_W | Group priority per vector, lower is more urgent |
| subPrio | input | NUM_SRC*SUB_W | Sub-priority per vector, lower is more urgent |
| handlerDone | input | 1 | One-cycle strobe from the core: running handler finished |
| enterStb | output | 1 | Enter a handler from idle |
| preemptStb | output | 1 | Preempt the running handler |
| chainStb | output | 1 | Tail-chain into the next handler |
| returnStb | output | 1 | Return to the stacked handler or to idle |
| vecNum | output | VEC_W | Vector tied to the current strobe, 0 otherwise |
| activeValid | output | 1 | A handler is running |
| activeVec | output | VEC_W | Vector of the running handler |
| pendMask | output | NUM_SRC | Sources currently pending |

## Verification
`pendMask` is combinational and is checked a moment after the inputs change, before any clock edge. Every decision strobe, together with `vecNum`, `activeValid` and `activeVec`, is due on the first rising edge after the stimulus. The bench therefore drives each change on a falling edge and reads the result on the next falling edge. The reading one falling edge later confirms that the strobe has dropped. Cases where nothing may happen, such as an equal group, a full stack or completion while idle, are held for several cycles, and every one of those cycles is checked to show no strobe.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // One decision per cycle, at most one field set.
  typedef struct packed {
    logic enter;
    logic preempt;
    logic chain;
    logic ret;
  } arbCmd_t;
endpackage

// File: rtl/irq_arb_ctl.sv
module irq_arb_ctl
  import irq_arb_pkg::*;
#(
  parameter int GRP_W = 3
) (
  input  logic             handlerDone,
  input  logic             anyPend,
  input  logic [GRP_W-1:0] bestGrp,
  input  logic             actValid,
  input  logic [GRP_W-1:0] actGrp,
  input  logic             stkEmpty,
  input  logic             stkFull,
  input  logic [GRP_W-1:0] topGrp,
  output arbCmd_t          cmd
);
  always_comb begin
    cmd = '0;
    if (!actValid) begin
      if (anyPend) cmd.enter = 1'b1;
    end else if (handlerDone) begin
      // Completion: chain when the winner outranks what a return would resume.
      if (anyPend && (stkEmpty || (bestGrp < topGrp))) cmd.chain = 1'b1;
      else                                             cmd.ret   = 1'b1;
    end else if (anyPend && !stkFull && (bestGrp < actGrp)) begin
      cmd.preempt = 1'b1;
    end
  end
endmodule

// File: rtl/irq_arb_dp.sv
module irq_arb_dp
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int GRP_W   = 3,
  parameter int SUB_W   = 2,
  parameter int DEPTH   = 4,
  localparam int VEC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int KEY_W  = GRP_W + SUB_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       reqLevel,
  input  logic [NUM_SRC-1:0]       reqEn,
  input  logic [NUM_SRC*GRP_W-1:0] grpPrio,
  input  logic [NUM_SRC*SUB_W-1:0] subPrio,
  input  arbCmd_t                  cmd,
  output logic                     anyPend,
  output logic [GRP_W-1:0]         bestGrp,
  output logic                     actValid,
  output logic [VEC_W-1:0]         actVec,
  output logic [GRP_W-1:0]         actGrp,
  output logic                     stkEmpty,
  output logic                     stkFull,
  output logic [GRP_W-1:0]         topGrp,
  output logic [NUM_SRC-1:0]       pendMask,
  output arbCmd_t                  stbQ,
  output logic [VEC_W-1:0]         vecQ
);
  logic [KEY_W-1:0] keyArr [NUM_SRC];
  logic [KEY_W-1:0] bestKey;
  logic [VEC_W-1:0] bestVec;
  logic [VEC_W-1:0] topVec;
  logic [VEC_W-1:0] stkVec [DEPTH];
  logic [GRP_W-1:0] stkGrp [DEPTH];
  logic [CNT_W-1:0] stkCnt;

  assign pendMask = reqLevel & reqEn;

  // Ranking key per source: group priority above sub-priority.
  for (genvar i = 0; i < NUM_SRC; i++) begin : gKey
    assign keyArr[i] = {grpPrio[i*GRP_W +: GRP_W], subPrio[i*SUB_W +: SUB_W]};
  end

  // Strict compare while scanning upward keeps the lowest index on a tie.
  always_comb begin
    anyPend = 1'b0;
    bestKey = '1;
    bestVec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pendMask[i] && (!anyPend || (keyArr[i] < bestKey))) begin
        anyPend = 1'b1;
        bestKey = keyArr[i];
        bestVec = VEC_W'(i);
      end
    end
  end
  assign bestGrp = bestKey[KEY_W-1:SUB_W];

  assign stkEmpty = (stkCnt == '0);
  assign stkFull  = (stkCnt == CNT_W'(DEPTH));

  always_comb begin
    topVec = '0;
    topGrp = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (stkCnt == CNT_W'(s + 1)) begin
        topVec = stkVec[s];
        topGrp = stkGrp[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actValid <= 1'b0;
      actVec   <= '0;
      actGrp   <= '0;
      stkCnt   <= '0;
      stbQ     <= '0;
      vecQ     <= '0;
      for (int s = 0; s < DEPTH; s++) begin
        stkVec[s] <= '0;
        stkGrp[s] <= '0;
      end
    end else begin
      stbQ <= cmd;
      vecQ <= '0;
      if (cmd.preempt) begin
        for (int s = 0; s < DEPTH; s++) begin
          if (stkCnt == CNT_W'(s)) begin
            stkVec[s] <= actVec;
            stkGrp[s] <= actGrp;
          end
        end
        stkCnt <= stkCnt + 1'b1;
      end
      if (cmd.enter || cmd.preempt || cmd.chain) begin
        actValid <= 1'b1;
        actVec   <= bestVec;
        actGrp   <= bestGrp;
        vecQ     <= bestVec;
      end else if (cmd.ret) begin
        if (!stkEmpty) begin
          actVec <= topVec;
          actGrp <= topGrp;
          vecQ   <= topVec;
          stkCnt <= stkCnt - 1'b1;
        end else begin
          actValid <= 1'b0;
          actVec   <= '0;
          actGrp   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int GRP_W   = 3,
  parameter int SUB_W   = 2,
  parameter int DEPTH   = 4,
  localparam int VEC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       reqLevel,
  input  logic [NUM_SRC-1:0]       reqEn,
  input  logic [NUM_SRC*GRP_W-1:0] grpPrio,
  input  logic [NUM_SRC*SUB_W-1:0] subPrio,
  input  logic                     handlerDone,
  output logic                     enterStb,
  output logic                     preemptStb,
  output logic                     chainStb,
  output logic                     returnStb,
  output logic [VEC_W-1:0]         vecNum,
  output logic                     activeValid,
  output logic [VEC_W-1:0]         activeVec,
  output logic [NUM_SRC-1:0]       pendMask
);
  arbCmd_t          cmd;
  arbCmd_t          stbQ;
  logic             anyPend;
  logic [GRP_W-1:0] bestGrp;
  logic [GRP_W-1:0] actGrp;
  logic [GRP_W-1:0] topGrp;
  logic             stkEmpty;
  logic             stkFull;

  irq_arb_ctl #(.GRP_W(GRP_W)) uCtl (
    .handlerDone(handlerDone), .anyPend(anyPend), .bestGrp(bestGrp),
    .actValid(activeValid), .actGrp(actGrp), .stkEmpty(stkEmpty),
    .stkFull(stkFull), .topGrp(topGrp), .cmd(cmd)
  );

  irq_arb_dp #(.NUM_SRC(NUM_SRC), .GRP_W(GRP_W), .SUB_W(SUB_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .reqLevel(reqLevel), .reqEn(reqEn),
    .grpPrio(grpPrio), .subPrio(subPrio), .cmd(cmd), .anyPend(anyPend),
    .bestGrp(bestGrp), .actValid(activeValid), .actVec(activeVec),
    .actGrp(actGrp), .stkEmpty(stkEmpty), .stkFull(stkFull), .topGrp(topGrp),
    .pendMask(pendMask), .stbQ(stbQ), .vecQ(vecNum)
  );

  assign enterStb   = stbQ.enter;
  assign preemptStb = stbQ.preempt;
  assign chainStb   = stbQ.chain;
  assign returnStb  = stbQ.ret;
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk #(
  parameter int NUM_SRC = 8,
  parameter int GRP_W   = 3,
  parameter int SUB_W   = 2,
  parameter int DEPTH   = 4,
  localparam int VEC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               handlerDone,
  input logic               enterStb,
  input logic               preemptStb,
  input logic               chainStb,
  input logic               returnStb,
  input logic [VEC_W-1:0]   vecNum,
  input logic               activeValid,
  input logic [VEC_W-1:0]   activeVec,
  input logic [NUM_SRC-1:0] pendMask
);
  // R10
  one_decision_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({enterStb, preemptStb, chainStb, returnStb}));

  // R2
  enter_from_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    enterStb |-> $past(!activeValid));

  // R2
  taken_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enterStb || preemptStb || chainStb) |-> (activeValid && (activeVec == vecNum)));

  // R5
  preempt_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    preemptStb |-> $past(activeValid && !handlerDone));

  // R6
  chain_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    chainStb |-> $past(activeValid && handlerDone));

  // R7
  return_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    returnStb |-> $past(activeValid && handlerDone));

  // R8
  idle_return_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (returnStb && !activeValid) |-> (vecNum == '0));

  // R11
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!activeValid && (pendMask == '0)) |->
      !(enterStb || preemptStb || chainStb || returnStb));
endmodule

bind irq_prio_arb irq_prio_arb_chk #(
  .NUM_SRC(NUM_SRC), .GRP_W(GRP_W), .SUB_W(SUB_W), .DEPTH(DEPTH)
) uChk (.*);

// File: tb/sim_irq_prio_arb.sv
`timescale 1ns/1ps
module sim_irq_prio_arb;
  localparam int NS = 8;
  localparam int GW = 3;
  localparam int SW = 2;
  localparam int DP = 4;
  localparam int VW = 3;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NS-1:0]  reqLevel = '0;
  logic [NS-1:0]  reqEn = '0;
  logic [NS*GW-1:0] grpPrio = '1;
  logic [NS*SW-1:0] subPrio = '1;
  logic           handlerDone = 1'b0;
  logic           enterStb, preemptStb, chainStb, returnStb;
  logic [VW-1:0]  vecNum;
  logic           activeValid;
  logic [VW-1:0]  activeVec;
  logic [NS-1:0]  pendMask;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_prio_arb #(.NUM_SRC(NS), .GRP_W(GW), .SUB_W(SW), .DEPTH(DP)) u0 (
    .clk(clk), .rstN(rstN), .reqLevel(reqLevel), .reqEn(reqEn),
    .grpPrio(grpPrio), .subPrio(subPrio), .handlerDone(handlerDone),
    .enterStb(enterStb), .preemptStb(preemptStb), .chainStb(chainStb),
    .returnStb(returnStb), .vecNum(vecNum), .activeValid(activeValid),
    .activeVec(activeVec), .pendMask(pendMask)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Strobe vector packed as {enter, preempt, chain, return}.
  task automatic expStb(string tag, int stb, int vec);
    chk(tag, "strobes", int'({enterStb, preemptStb, chainStb, returnStb}), stb);
    chk(tag, "vecNum", int'(vecNum), vec);
  endtask

  task automatic expAct(string tag, int valid, int vec);
    chk(tag, "activeValid", int'(activeValid), valid);
    chk(tag, "activeVec", int'(activeVec), vec);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic setP(int i, int g, int s);
    grpPrio[i*GW +: GW] = GW'(g);
    subPrio[i*SW +: SW] = SW'(s);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqLevel = '0;
    reqEn = '1;
    grpPrio = '1;
    subPrio = '1;
    handlerDone = 1'b0;
    step(); step();
    rstN = 1'b1;
    step();
  endtask

  task automatic doneAndStep();
    handlerDone = 1'b1;
    step();
    handlerDone = 1'b0;
  endtask

  task automatic tResetState();
    doReset();
    expStb("R10 reset", 0, 0);
    expAct("R2 reset", 0, 0);
    chk("R1 reset", "pendMask", int'(pendMask), 0);
  endtask

  task automatic tPendMask();
    doReset();
    reqEn = 8'h04;
    reqLevel = 8'h05;
    #1;
    chk("R1", "pendMask", int'(pendMask), 8'h04);
    step();
    expStb("R2 enter", 8, 2);
    expAct("R2 enter", 1, 2);
    step();
    expStb("R10 single cycle", 0, 0);
    reqLevel = 8'h04;
    doneAndStep();
    expStb("R6 own re-entry", 2, 2);
    reqLevel = 8'h01;
    doneAndStep();
    expStb("R1 disabled not entered", 1, 0);
    expAct("R8 idle", 0, 0);
    for (int k = 0; k < 3; k++) begin
      step();
      expStb("R1 disabled stays idle", 0, 0);
    end
  endtask

  task automatic tSelect();
    doReset();
    setP(1, 3, 2); setP(5, 3, 1); setP(6, 3, 1); setP(7, 5, 0);
    reqLevel = 8'hE2;
    step();
    expStb("R3 sub then index", 8, 5);
    doReset();
    setP(3, 2, 3); setP(4, 2, 3); setP(0, 4, 0);
    reqLevel = 8'h19;
    step();
    expStb("R3 group first tie low index", 8, 3);
  endtask

  task automatic tSameGroup();
    doReset();
    setP(2, 3, 2); setP(6, 3, 0);
    reqLevel = 8'h04;
    step();
    expStb("R2 enter", 8, 2);
    reqLevel = 8'h44;
    for (int k = 0; k < 3; k++) begin
      step();
      expStb("R4 no preempt", 0, 0);
    end
    expAct("R4 still running", 1, 2);
    doneAndStep();
    expStb("R6 chain sub-priority", 2, 6);
    doneAndStep();
    expStb("R6 chain own source", 2, 6);
    reqLevel = 8'h04;
    doneAndStep();
    expStb("R6 chain remaining", 2, 2);
    reqLevel = 8'h00;
    doneAndStep();
    expStb("R8 return idle", 1, 0);
    expAct("R8 idle", 0, 0);
  endtask

  task automatic tPreemptReturn();
    doReset();
    setP(4, 4, 3); setP(1, 1, 0); setP(6, 4, 0);
    reqLevel = 8'h10;
    step();
    expStb("R2 enter", 8, 4);
    reqLevel = 8'h12;
    step();
    expStb("R5 preempt", 4, 1);
    expAct("R5 preempt", 1, 1);
    reqLevel = 8'h52;
    step();
    expStb("R4 lower group waits", 0, 0);
    reqLevel = 8'h50;
    doneAndStep();
    expStb("R7 return to stacked", 1, 4);
    expAct("R7 resumed", 1, 4);
    reqLevel = 8'h40;
    doneAndStep();
    expStb("R6 chain empty stack", 2, 6);
    reqLevel = 8'h00;
    doneAndStep();
    expStb("R8 return idle", 1, 0);
    expAct("R8 idle", 0, 0);
  endtask

  task automatic tStackFull();
    doReset();
    setP(7, 6, 0); setP(6, 5, 0); setP(5, 4, 0); setP(4, 3, 0);
    setP(3, 2, 0); setP(2, 1, 0);
    reqLevel = 8'h80;
    step();
    expStb("R2 enter", 8, 7);
    for (int v = 6; v >= 3; v--) begin
      reqLevel[v] = 1'b1;
      step();
      expStb("R5 nested preempt", 4, v);
    end
    reqLevel[2] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      expStb("R9 full stack holds", 0, 0);
    end
    expAct("R9 still running", 1, 3);
    reqLevel[3] = 1'b0;
    doneAndStep();
    expStb("R6 chain beats stack top", 2, 2);
  endtask

  task automatic tDoneIdle();
    doReset();
    doneAndStep();
    expStb("R11 done idle", 0, 0);
    expAct("R11 done idle", 0, 0);
    step();
    expStb("R11 done idle later", 0, 0);
  endtask

  initial begin
    tResetState();
    tPendMask();
    tSelect();
    tSameGroup();
    tPreemptReturn();
    tStackFull();
    tDoneIdle();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule